// File: doc/BRIEF.md
# Mode-Status Register with Exception Vector Selection

This block keeps the processor's mode word and turns it into the signals the pipeline needs when an exception is taken. Software writes a 32-bit status word with a strobe and can read it back at any time. Only the implemented fields hold state. Every other bit reads as zero, and writes to those bits are lost. The stored fields are sent out as separate flags: reduced-power request, 64-bit float-register view, reversed user byte order, branch trace enable, and three extended-addressing enables, one for each privilege level.

The exception logic gives the block an exception class, the current privilege level and an exception/error-level flag. The block returns the entry address at once, in the same cycle. That address depends on the bootstrap bit, on the class, and for a TLB refill on the extended-addressing enable of the effective privilege. The block also combines eight pending interrupt lines with the mask field and the global enable, and asserts an accept signal when an ordinary interrupt may be taken. Reset and NMI are never masked: they always receive the fixed boot-root vector.

Top module: `stvec_ctrl`

## Requirements
- R1: After reset (asynchronous, `rst_n` low) the status word reads 0x00400000. The bootstrap bit (22) is 1 and every other bit is 0, so the reduced-power and float-view flags are clear.
- R2: A write with `st_wr` high is visible on `st_rdata` from the next rising clock edge onward. Readback equals the written data ANDed with 0x0F40FFE1. The implemented bits are 27..24, 22, 15..8, 7..5 and 0, and all other bits read as zero.
- R3: The flags follow stored bits: `rp_req`=27, `fr_mode`=26, `rev_endian`=25, `trace_en`=24, `kx_en`=7, `sx_en`=6, `ux_en`=5.
- R4: The class code `exc_cls` is: 0 general, 1 TLB refill, 2 interrupt, 3 reset, 4 NMI, and 5..7 are treated as general. For codes 3 and 4, `vec_addr` is 0xBFC00000 whatever the bootstrap bit holds.
- R5: For general, interrupt and unknown classes, `vec_addr` is 0x80000180 when bit 22 is clear and 0xBFC00380 when it is set.
- R6: A TLB refill without extended addressing gives 0x80000000 (bit 22 clear) or 0xBFC00200 (bit 22 set).
- R7: A TLB refill whose effective privilege has its extended bit set adds 0x080, giving 0x80000080 or 0xBFC00280. The privilege code `priv` is 00 kernel (bit 7), 01 supervisor (bit 6), 10 user (bit 5).
- R8: When `exl` is high, or when `priv` is 11, kernel is used for vector selection, so bit 7 decides whether the refill is extended.
- R9: `irq_accept` is high exactly when bit 0 is 1 and at least one `irq_pend[i]` is high while status bit 8+i is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 32 | Status write data |
| st_rdata | output | 32 | Status readback |
| exc_cls | input | 3 | Exception class code |
| priv | input | 2 | Current privilege level |
| exl | input | 1 | Exception or error level active |
| irq_pend | input | 8 | Pending interrupt lines |
| vec_addr | output | 32 | Exception entry address |
| irq_accept | output | 1 | Ordinary interrupt may be taken |
| rp_req | output | 1 | Reduced-power request |
| fr_mode | output | 1 | Full 64-bit float-register view |
| rev_endian | output | 1 | Reversed user byte order |
| trace_en | output | 1 | Branch trace enable |
| kx_en | output | 1 | Kernel extended addressing |
| sx_en | output | 1 | Supervisor extended addressing |
| ux_en | output | 1 | User extended addressing |

## Verification
The extended refill vector with the bootstrap bit set is the hardest case to reach. Four conditions must line up: bit 22 written back to 1 after software has cleared it, the extended bit of the effective privilege set, the refill class presented, and `exl` or privilege code 11 redirecting the choice to kernel. Random stimulus seldom hits all four together. Directed sequences therefore load status words that set one extended bit and clear the others, then present a user privilege with `exl` both low and high. The random phase writes mostly full-width random words and also drives every class code, all four privilege codes, and random pending lines.

// File: rtl/stvec_pkg.sv
package stvec_pkg;

  localparam int unsigned STW   = 32;
  localparam int unsigned IRQ_N = 8;

  localparam int unsigned B_RP    = 27;
  localparam int unsigned B_FR    = 26;
  localparam int unsigned B_RE    = 25;
  localparam int unsigned B_TRACE = 24;
  localparam int unsigned B_BEV   = 22;
  localparam int unsigned B_IM_LO = 8;
  localparam int unsigned B_KX    = 7;
  localparam int unsigned B_SX    = 6;
  localparam int unsigned B_UX    = 5;
  localparam int unsigned B_IE    = 0;

  localparam logic [STW-1:0] VEC_BOOT_ROOT = 32'hBFC0_0000;
  localparam logic [STW-1:0] BASE_BOOT     = 32'hBFC0_0200;
  localparam logic [STW-1:0] BASE_NORM     = 32'h8000_0000;
  localparam logic [STW-1:0] OFF_XREFILL   = 32'h0000_0080;
  localparam logic [STW-1:0] OFF_GENERAL   = 32'h0000_0180;

  typedef enum logic [2:0] {
    EXC_GENERAL = 3'd0,
    EXC_REFILL  = 3'd1,
    EXC_IRQ     = 3'd2,
    EXC_RESET   = 3'd3,
    EXC_NMI     = 3'd4
  } exc_cls_e;

  localparam logic [1:0] PRIV_KERNEL = 2'b00;
  localparam logic [1:0] PRIV_SUPER  = 2'b01;
  localparam logic [1:0] PRIV_USER   = 2'b10;

  typedef struct packed {
    logic             rp;
    logic             fr;
    logic             re;
    logic             trace;
    logic             bev;
    logic [IRQ_N-1:0] im;
    logic             kx;
    logic             sx;
    logic             ux;
    logic             ie;
  } mode_t;

  function automatic logic [STW-1:0] impl_mask();
    logic [STW-1:0] m;
    m = '0;
    m[B_RP] = 1'b1;
    m[B_FR] = 1'b1;
    m[B_RE] = 1'b1;
    m[B_TRACE] = 1'b1;
    m[B_BEV] = 1'b1;
    for (int i = 0; i < int'(IRQ_N); i++) m[B_IM_LO + i] = 1'b1;
    m[B_KX] = 1'b1;
    m[B_SX] = 1'b1;
    m[B_UX] = 1'b1;
    m[B_IE] = 1'b1;
    return m;
  endfunction

  localparam logic [STW-1:0] WR_MASK   = impl_mask();
  localparam logic [STW-1:0] RESET_VAL = STW'(1) << B_BEV;

  function automatic mode_t decode_status(input logic [STW-1:0] s);
    mode_t m;
    m.rp    = s[B_RP];
    m.fr    = s[B_FR];
    m.re    = s[B_RE];
    m.trace = s[B_TRACE];
    m.bev   = s[B_BEV];
    m.im    = s[B_IM_LO +: IRQ_N];
    m.kx    = s[B_KX];
    m.sx    = s[B_SX];
    m.ux    = s[B_UX];
    m.ie    = s[B_IE];
    return m;
  endfunction

  // Privilege used for vector choice: exception level or code 11 -> kernel.
  function automatic logic [1:0] effective_priv(input logic [1:0] p, input logic lvl);
    if (lvl || p == 2'b11) return PRIV_KERNEL;
    return p;
  endfunction

  function automatic logic ext_for_priv(input logic [1:0] ep, input logic kx,
                                        input logic sx, input logic ux);
    case (ep)
      PRIV_SUPER: return sx;
      PRIV_USER:  return ux;
      default:    return kx;
    endcase
  endfunction

  function automatic logic [STW-1:0] entry_addr(input logic [2:0] cls, input logic bev,
                                                input logic ext);
    logic [STW-1:0] base;
    base = bev ? BASE_BOOT : BASE_NORM;
    case (cls)
      EXC_RESET, EXC_NMI: return VEC_BOOT_ROOT;
      EXC_REFILL:         return base + (ext ? OFF_XREFILL : '0);
      default:            return base + OFF_GENERAL;
    endcase
  endfunction

endpackage

// File: rtl/stvec_status_reg.sv
module stvec_status_reg
  import stvec_pkg::*;
#(
  parameter int unsigned W = STW,
  parameter logic [W-1:0] IMPL = WR_MASK,
  parameter logic [W-1:0] RST  = RESET_VAL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < int'(W); i++) begin : g_bit
    if (IMPL[i]) begin : g_ff
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bit_q <= RST[i];
        else if (wr_en) bit_q <= wr_data[i];
      end
      assign q[i] = bit_q;
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^(wr_data & ~IMPL);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (q & ~IMPL) == '0) else $error("reserved status bit set"); // R2
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> q == ($past(wr_data) & IMPL)) else $error("status write lost"); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(q)) else $error("status changed without write"); // R2

endmodule

// File: rtl/stvec_vector_sel.sv
module stvec_vector_sel
  import stvec_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     cls,
  input  logic [1:0]     priv,
  input  logic           lvl,
  input  logic           bev,
  input  logic           kx,
  input  logic           sx,
  input  logic           ux,
  output logic [1:0]     eff_priv,
  output logic           use_ext,
  output logic [STW-1:0] vec
);

  logic is_root;

  always_comb begin
    eff_priv = effective_priv(priv, lvl);
    use_ext  = ext_for_priv(eff_priv, kx, sx, ux);
    vec      = entry_addr(cls, bev, use_ext);
    is_root  = (cls == EXC_RESET) || (cls == EXC_NMI);
  end

  AST_ROOT_FIXED: assert property (@(posedge clk) disable iff (!rst_n) is_root |-> vec == VEC_BOOT_ROOT) else $error("root vector wrong"); // R4
  AST_BOOT_REGION: assert property (@(posedge clk) disable iff (!rst_n) bev |-> vec[31:12] == 20'hBFC00) else $error("vector outside boot region"); // R5
  AST_NORM_REGION: assert property (@(posedge clk) disable iff (!rst_n) (!bev && !is_root) |-> vec[31:12] == 20'h80000) else $error("vector outside normal region"); // R6
  AST_LEVEL_KERNEL: assert property (@(posedge clk) disable iff (!rst_n) lvl |-> eff_priv == PRIV_KERNEL) else $error("level did not force kernel"); // R8

endmodule

// File: rtl/stvec_irq_gate.sv
module stvec_irq_gate #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ie,
  input  logic [N-1:0] im,
  input  logic [N-1:0] pend,
  output logic [N-1:0] unmasked,
  output logic         accept
);

  always_comb begin
    unmasked = pend & im;
    accept   = ie && (unmasked != '0);
  end

  AST_IE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) !ie |-> !accept) else $error("accept with interrupts disabled"); // R9
  AST_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n) accept |-> (pend & im) != '0) else $error("accept with no enabled pending line"); // R9

endmodule

// File: rtl/stvec_ctrl.sv
module stvec_ctrl
  import stvec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        st_wr,
  input  logic [31:0] st_wdata,
  output logic [31:0] st_rdata,
  input  logic [2:0]  exc_cls,
  input  logic [1:0]  priv,
  input  logic        exl,
  input  logic [7:0]  irq_pend,
  output logic [31:0] vec_addr,
  output logic        irq_accept,
  output logic        rp_req,
  output logic        fr_mode,
  output logic        rev_endian,
  output logic        trace_en,
  output logic        kx_en,
  output logic        sx_en,
  output logic        ux_en
);

  logic [STW-1:0]   status_q;
  mode_t            mode;
  logic [1:0]       eff_priv;
  logic             use_ext;
  logic [IRQ_N-1:0] unmasked;

  stvec_status_reg #(.W(STW), .IMPL(WR_MASK), .RST(RESET_VAL)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (st_wr),
    .wr_data (st_wdata),
    .q       (status_q)
  );

  assign mode = decode_status(status_q);

  stvec_vector_sel u_vsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .cls      (exc_cls),
    .priv     (priv),
    .lvl      (exl),
    .bev      (mode.bev),
    .kx       (mode.kx),
    .sx       (mode.sx),
    .ux       (mode.ux),
    .eff_priv (eff_priv),
    .use_ext  (use_ext),
    .vec      (vec_addr)
  );

  stvec_irq_gate #(.N(IRQ_N)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ie       (mode.ie),
    .im       (mode.im),
    .pend     (irq_pend),
    .unmasked (unmasked),
    .accept   (irq_accept)
  );

  assign st_rdata   = status_q;
  assign rp_req     = mode.rp;
  assign fr_mode    = mode.fr;
  assign rev_endian = mode.re;
  assign trace_en   = mode.trace;
  assign kx_en      = mode.kx;
  assign sx_en      = mode.sx;
  assign ux_en      = mode.ux;

  AST_EXT_ONLY_REFILL: assert property (@(posedge clk) disable iff (!rst_n) (exc_cls == EXC_REFILL && use_ext) |-> vec_addr[7:0] == 8'h80) else $error("extended refill offset wrong"); // R7
  AST_RESET_BOOT: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> st_rdata == RESET_VAL) else $error("reset value wrong"); // R1
  AST_FLAG_RP: assert property (@(posedge clk) disable iff (!rst_n) st_wr |=> rp_req == $past(st_wdata[B_RP])) else $error("rp flag mismatch"); // R3

endmodule

// File: tb/test_stvec_ctrl.sv
module test_stvec_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_wr = 1'b0;
  logic [31:0] st_wdata = '0;
  logic [31:0] st_rdata;
  logic [2:0]  exc_cls = '0;
  logic [1:0]  priv = '0;
  logic        exl = 1'b0;
  logic [7:0]  irq_pend = '0;
  logic [31:0] vec_addr;
  logic        irq_accept, rp_req, fr_mode, rev_endian, trace_en, kx_en, sx_en, ux_en;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] model;

  always #5 clk = ~clk;

  stvec_ctrl i_stvec_ctrl (
    .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .st_wdata(st_wdata), .st_rdata(st_rdata),
    .exc_cls(exc_cls), .priv(priv), .exl(exl), .irq_pend(irq_pend),
    .vec_addr(vec_addr), .irq_accept(irq_accept), .rp_req(rp_req), .fr_mode(fr_mode),
    .rev_endian(rev_endian), .trace_en(trace_en), .kx_en(kx_en), .sx_en(sx_en), .ux_en(ux_en)
  );

  function automatic logic [31:0] keep_bits(input logic [31:0] d);
    return {4'b0, d[27:24], 1'b0, d[22], 6'b0, d[15:5], 4'b0, d[0]};
  endfunction

  function automatic logic [31:0] want_vec(input logic [31:0] s, input logic [2:0] c,
                                           input logic [1:0] p, input logic x);
    logic ext;
    logic [31:0] hi;
    if (c == 3'd3 || c == 3'd4) return 32'hBFC0_0000;
    if (x) ext = s[7];
    else if (p == 2'b01) ext = s[6];
    else if (p == 2'b10) ext = s[5];
    else ext = s[7];
    hi = s[22] ? 32'hBFC0_0000 : 32'h8000_0000;
    if (c == 3'd1) return hi | (s[22] ? 32'h200 : 32'h0) | (ext ? 32'h80 : 32'h0);
    return hi | (s[22] ? 32'h380 : 32'h180);
  endfunction

  function automatic logic want_acc(input logic [31:0] s, input logic [7:0] pd);
    for (int i = 0; i < 8; i++) if (s[0] && s[8+i] && pd[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 readback", st_rdata, model);
    chk("R3 flags", {25'b0, rp_req, fr_mode, rev_endian, trace_en, kx_en, sx_en, ux_en},
        {25'b0, model[27], model[26], model[25], model[24], model[7], model[6], model[5]});
    chk("R4 R5 R6 R7 R8 vector", vec_addr, want_vec(model, exc_cls, priv, exl));
    chk("R9 accept", {31'b0, irq_accept}, {31'b0, want_acc(model, irq_pend)});
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    st_wr = 1'b1; st_wdata = d;
    @(negedge clk);
    st_wr = 1'b0;
    model = keep_bits(d);
    #1;
  endtask

  task automatic probe(input logic [2:0] c, input logic [1:0] p, input logic x,
                       input logic [31:0] exp, input string req);
    exc_cls = c; priv = p; exl = x;
    #1;
    chk(req, vec_addr, exp);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1325));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    model = 32'h0040_0000;
    chk("R1 reset word", st_rdata, 32'h0040_0000);
    chk("R1 rp/fr clear", {30'b0, rp_req, fr_mode}, 32'b0);

    // R2 write-all and write-none
    wr(32'hFFFF_FFFF);
    chk("R2 implemented mask", st_rdata, 32'h0F40_FFE1);
    check_all();
    // R2 write not visible before the edge
    @(negedge clk);
    st_wr = 1'b1; st_wdata = 32'h0;
    #1;
    chk("R2 not before edge", st_rdata, 32'h0F40_FFE1);
    @(negedge clk);
    st_wr = 1'b0; model = 32'h0;
    #1;
    chk("R2 cleared", st_rdata, 32'h0);

    // R4 root vector independent of bootstrap bit
    probe(3'd3, 2'b10, 1'b0, 32'hBFC0_0000, "R4 reset bev=0");
    probe(3'd4, 2'b00, 1'b0, 32'hBFC0_0000, "R4 nmi bev=0");
    // R5 / R6 with bootstrap clear
    probe(3'd0, 2'b00, 1'b0, 32'h8000_0180, "R5 general bev=0");
    probe(3'd2, 2'b01, 1'b0, 32'h8000_0180, "R5 interrupt bev=0");
    probe(3'd7, 2'b00, 1'b0, 32'h8000_0180, "R5 unknown class");
    probe(3'd1, 2'b10, 1'b0, 32'h8000_0000, "R6 refill bev=0");

    // R7 user extended only, bootstrap set
    wr(32'h0040_0020);
    probe(3'd1, 2'b10, 1'b0, 32'hBFC0_0280, "R7 user ext bev=1");
    probe(3'd1, 2'b01, 1'b0, 32'hBFC0_0200, "R7 super not ext");
    probe(3'd1, 2'b10, 1'b1, 32'hBFC0_0200, "R8 exl forces kernel");
    probe(3'd0, 2'b10, 1'b0, 32'hBFC0_0380, "R5 general bev=1");
    probe(3'd3, 2'b10, 1'b0, 32'hBFC0_0000, "R4 reset bev=1");
    // R8 kernel ext only
    wr(32'h0000_0080);
    probe(3'd1, 2'b11, 1'b0, 32'h8000_0080, "R8 priv11 as kernel");
    probe(3'd1, 2'b10, 1'b1, 32'h8000_0080, "R8 exl user->kernel ext");
    probe(3'd1, 2'b10, 1'b0, 32'h8000_0000, "R7 user clear");
    wr(32'h0000_0040);
    probe(3'd1, 2'b01, 1'b0, 32'h8000_0040 + 32'h40, "R7 super ext");

    // R9 masking corners
    wr(32'h0000_0400);
    irq_pend = 8'h04; #1;
    chk("R9 ie clear blocks", {31'b0, irq_accept}, 32'b0);
    wr(32'h0000_0401);
    #1;
    chk("R9 enabled line", {31'b0, irq_accept}, 32'b1);
    irq_pend = 8'hFB; #1;
    chk("R9 masked lines", {31'b0, irq_accept}, 32'b0);

    // random phase
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      exc_cls = 3'($urandom_range(0, 7));
      priv = 2'($urandom_range(0, 3));
      exl = ($urandom_range(0, 3) == 0);
      irq_pend = 8'($urandom);
      st_wr = ($urandom_range(0, 2) == 0);
      st_wdata = $urandom;
      #1;
      check_all();
      if (st_wr) model = keep_bits(st_wdata);
    end
    @(negedge clk);
    st_wr = 1'b0;
    #1;
    check_all();

    // R1 again after a mid-run reset
    wr(32'h0F00_0000);
    rst_n = 1'b0;
    #1;
    rst_n = 1'b1;
    model = 32'h0040_0000;
    #1;
    chk("R1 reset mid-run", st_rdata, 32'h0040_0000);
    chk("R1 rp cleared", {31'b0, rp_req}, 32'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule